// File: doc/BRIEF.md
# Command ring fetch engine

This block is the controller side of a circular command ring kept in a small local memory. Host software writes 32-bit command words into ring slots through a write port. It then publishes the newest slot index through a write-pointer register. While the run bit is set, the engine walks the ring one slot at a time, starting just after its read pointer and ending at the write pointer. Each word it reads is offered on a valid/ready output toward the codec link. The top four bits of the word are also brought out as a separate codec address.

A small register interface gives software the write pointer, the read pointer, a ring-size code and a control register. The read pointer has a two-step reset. Writing the reset flag forces the pointer to zero, and the flag reads back as set. Writing zero then releases it. No fetching happens while the flag is held. Because fetching always begins at read pointer + 1, slot 0 is never the first word sent after a pointer reset.

The sequencer has three states. `ST_IDLE` waits for work. `ST_READ` issues the memory read. `ST_OFFER` presents the word. The transitions are:
- `ST_IDLE -> ST_READ` when run is set, the reset flag is clear and the masked write pointer differs from the read pointer.
- `ST_READ -> ST_OFFER` normally, or `ST_READ -> ST_IDLE` on a pointer reset.
- `ST_OFFER -> ST_IDLE` on acceptance, which also advances the read pointer, or on a pointer reset, which drops the word.

Register map, used on both the write and the read port:
- Address 0 is the write pointer.
- Address 1 is the read pointer, with its reset flag in bit 15.
- Address 2 is the size code, in bits 1:0.
- Address 3 is control, with run in bit 0.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset the write pointer, read pointer and control registers read 0x0000, the size code reads 0x0002, and cmd_valid is low.
- R2: Words are offered in ring order from slot (read pointer + 1) up to and including the write-pointer slot. After a pointer reset the slot-0 word is not the first one offered.
- R3: Each accepted word (cmd_valid and cmd_ready high at a clock edge) advances the read pointer by one, modulo the ring size, and the new value is readable at address 1.
- R4: Writing a value with bit 15 set to address 1 sets the read pointer to 0, and the register then reads 0x8000. While that flag is held nothing is offered. Writing 0x0000 to address 1 clears the flag, the register reads 0x0000, and fetching resumes.
- R5: While the run bit (address 3, bit 0) is 0, no new fetch starts and cmd_valid stays low.
- R6: While cmd_valid is high and cmd_ready is low, cmd_valid and cmd_data hold their values until acceptance, unless the read pointer is reset.
- R7: cmd_codec equals bits 31:28 of the offered cmd_data.
- R8: Pointer registers are 16 bits wide with only bits 7:0 kept. The write pointer reads back with bits 15:8 as zero, and a write to those bits starts no fetch.
- R9: The read pointer wraps from 255 to 0 with size code 2 (256 slots), and words keep their order across the wrap.
- R10: The size code selects the ring length: 0 gives 2 slots, 1 gives 16 slots, and 2 or 3 give 256 slots. Pointers wrap at that length.
- R11: When the write pointer is advanced after the engine has gone idle with the pointers equal, fetching restarts with no word lost or repeated.
- R12: A read-pointer reset written while a word is pending or offered drops that word: cmd_valid is low in the following cycle and the word is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 16 | Register read data (combinational) |
| ring_wr_en | input | 1 | Ring slot write strobe |
| ring_wr_idx | input | 8 | Ring slot index to write |
| ring_wr_data | input | 32 | Command word to store |
| cmd_valid | output | 1 | A command word is offered |
| cmd_ready | input | 1 | Link side accepts the offered word |
| cmd_data | output | 32 | Offered command word |
| cmd_codec | output | 4 | Codec address field of the offered word |

## Verification
The assertions check the cycle-level rules on every cycle:
- the held valid and data during back-pressure;
- the single-step pointer advance on acceptance;
- no offer while the reset flag is held or while there is nothing to fetch;
- no departure from idle with run cleared;
- the dropped word after a pointer reset.

Order across the wrap, the slot-0 exclusion, the size-code wrap lengths and loss-free restarts only show up in the bench scenarios. There, a scoreboard compares every accepted word against the sequence software queued under random back-pressure.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_OFFER = 2'd2
    } fetch_state_t;

    localparam logic [1:0] RA_WPTR = 2'd0;
    localparam logic [1:0] RA_RPTR = 2'd1;
    localparam logic [1:0] RA_SIZE = 2'd2;
    localparam logic [1:0] RA_CTRL = 2'd3;

    localparam logic [1:0] SIZE_CODE_RESET = 2'd2;

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             advance,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] mask,
    output logic             run,
    output logic             rst_hold,
    output logic             rp_clear
);
    localparam int RST_BIT = REG_W - 1;
    localparam int PAD_W   = REG_W - 1 - PTR_W;

    logic [1:0] size_code;
    logic       wr_wp, wr_rp, wr_sz, wr_ctl;

    assign wr_wp  = wr_en && (wr_addr == RA_WPTR);
    assign wr_rp  = wr_en && (wr_addr == RA_RPTR);
    assign wr_sz  = wr_en && (wr_addr == RA_SIZE);
    assign wr_ctl = wr_en && (wr_addr == RA_CTRL);

    assign rp_clear = wr_rp && wr_data[RST_BIT];

    always_comb begin
        unique case (size_code)
            2'd0:    mask = PTR_W'(1);
            2'd1:    mask = PTR_W'(15);
            default: mask = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            size_code <= SIZE_CODE_RESET;
            run       <= 1'b0;
        end else begin
            if (wr_wp)  wptr      <= wr_data[PTR_W-1:0];
            if (wr_sz)  size_code <= wr_data[1:0];
            if (wr_ctl) run       <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            rst_hold <= 1'b0;
        end else if (rp_clear) begin
            rptr     <= '0;
            rst_hold <= 1'b1;
        end else if (wr_rp) begin
            rst_hold <= 1'b0;
        end else if (advance) begin
            rptr <= (rptr + PTR_W'(1)) & mask;
        end
    end

    always_comb begin
        unique case (rd_addr)
            RA_WPTR: rd_data = {1'b0, {PAD_W{1'b0}}, wptr};
            RA_RPTR: rd_data = {rst_hold, {PAD_W{1'b0}}, rptr};
            RA_SIZE: rd_data = {{(REG_W-2){1'b0}}, size_code};
            RA_CTRL: rd_data = {{(REG_W-1){1'b0}}, run};
        endcase
    end

endmodule

// File: rtl/cmd_ring_mem.sv
module cmd_ring_mem #(
    parameter int CMD_W = 32,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [CMD_W-1:0] rd_q
);
    localparam int DEPTH = 1 << PTR_W;

    logic [CMD_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= slots[rd_idx];
    end

endmodule

// File: rtl/cmd_ring_seq.sv
module cmd_ring_seq
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rst_hold,
    input  logic             rp_clear,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic [PTR_W-1:0] mask,
    input  logic             out_ready,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_idx,
    output logic             out_valid,
    output logic             advance,
    output fetch_state_t     state
);
    fetch_state_t state_nxt;
    logic         pending;

    assign pending = ((wptr & mask) != rptr);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (run && !rst_hold && !rp_clear && pending)
                    state_nxt = ST_READ;
            end
            ST_READ: begin
                if (rp_clear || rst_hold) state_nxt = ST_IDLE;
                else                      state_nxt = ST_OFFER;
            end
            ST_OFFER: begin
                if (rp_clear || out_ready) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_en     = 1'b0;
        out_valid = 1'b0;
        advance   = 1'b0;
        rd_idx    = (rptr + PTR_W'(1)) & mask;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  rd_en = 1'b1;
            ST_OFFER: begin
                out_valid = 1'b1;
                advance   = out_ready && !rp_clear;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int CMD_W   = 32,
    parameter int PTR_W   = 8,
    parameter int REG_W   = 16,
    parameter int CODEC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_addr,
    input  logic [REG_W-1:0]   reg_wr_data,
    input  logic [1:0]         reg_rd_addr,
    output logic [REG_W-1:0]   reg_rd_data,
    input  logic               ring_wr_en,
    input  logic [PTR_W-1:0]   ring_wr_idx,
    input  logic [CMD_W-1:0]   ring_wr_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_data,
    output logic [CODEC_W-1:0] cmd_codec
);
    logic [PTR_W-1:0] wptr_w, rptr_w, mask_w, rd_idx_w;
    logic             run_w, rst_hold_w, rp_clear_w, advance_w, rd_en_w;
    fetch_state_t     fsm_state;

    cmd_ring_regs #(.PTR_W(PTR_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .advance(advance_w),
        .wptr(wptr_w), .rptr(rptr_w), .mask(mask_w),
        .run(run_w), .rst_hold(rst_hold_w), .rp_clear(rp_clear_w)
    );

    cmd_ring_mem #(.CMD_W(CMD_W), .PTR_W(PTR_W)) u_mem (
        .clk(clk),
        .wr_en(ring_wr_en), .wr_idx(ring_wr_idx), .wr_data(ring_wr_data),
        .rd_en(rd_en_w), .rd_idx(rd_idx_w), .rd_q(cmd_data)
    );

    cmd_ring_seq #(.PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .run(run_w), .rst_hold(rst_hold_w), .rp_clear(rp_clear_w),
        .wptr(wptr_w), .rptr(rptr_w), .mask(mask_w),
        .out_ready(cmd_ready),
        .rd_en(rd_en_w), .rd_idx(rd_idx_w),
        .out_valid(cmd_valid), .advance(advance_w),
        .state(fsm_state)
    );

    assign cmd_codec = cmd_data[CMD_W-1 -: CODEC_W];

endmodule

// File: rtl/cmd_ring_fetch_chk.sv
module cmd_ring_fetch_chk #(
    parameter int CMD_W = 32,
    parameter int PTR_W = 8,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_wr_addr,
    input logic [REG_W-1:0] reg_wr_data,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CMD_W-1:0] cmd_data,
    input logic [PTR_W-1:0] rptr,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] mask,
    input logic             run,
    input logic             rst_hold,
    input logic [1:0]       state_q
);
    logic rp_rst_wr;
    assign rp_rst_wr = reg_wr_en && (reg_wr_addr == 2'd1) && reg_wr_data[REG_W-1];

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !rp_rst_wr) |=> (cmd_valid && $stable(cmd_data)));

    // R3
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !rp_rst_wr) |=> (rptr == (($past(rptr) + PTR_W'(1)) & $past(mask))));

    // R4
    hold_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold |-> !cmd_valid);

    // R12
    reset_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_rst_wr |=> !cmd_valid);

    // R2
    offer_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((wptr & mask) != rptr));

    // R5
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && state_q == 2'd0) |=> (state_q == 2'd0));

endmodule

bind cmd_ring_fetch cmd_ring_fetch_chk #(.CMD_W(CMD_W), .PTR_W(PTR_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rptr(rptr_w), .wptr(wptr_w), .mask(mask_w),
    .run(run_w), .rst_hold(rst_hold_w), .state_q(fsm_state)
);

// File: tb/sim_cmd_ring_fetch.sv
module sim_cmd_ring_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [15:0] reg_rd_data;
    logic        ring_wr_en = 1'b0;
    logic [7:0]  ring_wr_idx = '0;
    logic [31:0] ring_wr_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_codec;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_q [$];
    int          sw_wp = 0;
    int          sw_mask = 255;
    int          rdy_mode = 2;
    logic [15:0] lfsr = 16'hACE1;
    bit          drop_ok = 1'b0;

    always #10 clk = ~clk;

    cmd_ring_fetch u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .ring_wr_en(ring_wr_en), .ring_wr_idx(ring_wr_idx), .ring_wr_data(ring_wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_codec(cmd_codec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        reg_rd_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic ring_put(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        ring_wr_en = 1'b1; ring_wr_idx = idx; ring_wr_data = d;
        @(negedge clk);
        ring_wr_en = 1'b0;
    endtask

    task automatic push_cmd(input logic [31:0] d);
        int nxt;
        logic [15:0] rp;
        nxt = (sw_wp + 1) & sw_mask;
        rd_reg(2'd1, rp);
        while (int'(rp[7:0]) == nxt) begin
            @(negedge clk);
            rd_reg(2'd1, rp);
        end
        ring_put(8'(nxt), d);
        exp_q.push_back(d);
        wr_reg(2'd0, 16'(nxt));
        sw_wp = nxt;
    endtask

    task automatic drain(input string req);
        int left;
        left = 20000;
        while (exp_q.size() != 0 && left > 0) begin
            @(negedge clk);
            left--;
        end
        if (exp_q.size() != 0) chk({req, " drain"}, 32'(exp_q.size()), 32'd0);
        repeat (4) @(negedge clk);
    endtask

    // ready driver, changes away from both edges used for sampling
    initial begin
        forever begin
            @(posedge clk);
            #3;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       cmd_ready = 1'b0;
                1:       cmd_ready = lfsr[0];
                default: cmd_ready = 1'b1;
            endcase
        end
    end

    // monitor / scoreboard
    initial begin
        logic        pv, pr;
        logic [31:0] pd;
        logic [31:0] e;
        pv = 1'b0; pr = 1'b0; pd = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pv && !pr && !drop_ok) begin
                    chk("R6 valid held", 32'(cmd_valid), 32'd1);
                    chk("R6 data held", cmd_data, pd);
                end
                if (cmd_valid && cmd_ready) begin
                    if (exp_q.size() == 0) begin
                        chk("R2 unexpected word", cmd_data, 32'hFFFF_FFFF);
                    end else begin
                        e = exp_q.pop_front();
                        chk("R2 order", cmd_data, e);
                        chk("R7 codec", 32'(cmd_codec), 32'(e[31:28]));
                    end
                end
            end
            pv = cmd_valid; pr = cmd_ready; pd = cmd_data;
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_reg(2'd0, v); chk("R1 wptr", 32'(v), 32'h0);
        rd_reg(2'd1, v); chk("R1 rptr", 32'(v), 32'h0);
        rd_reg(2'd2, v); chk("R1 size", 32'(v), 32'h2);
        rd_reg(2'd3, v); chk("R1 ctrl", 32'(v), 32'h0);
        chk("R1 valid", 32'(cmd_valid), 32'd0);

        // R5 run clear: nothing fetched; slot 0 holds a sentinel (R2)
        rdy_mode = 2;
        ring_put(8'd0, 32'hDEAD_0000);
        push_cmd(32'h1000_0001);
        push_cmd(32'h2000_0002);
        push_cmd(32'h3000_0003);
        repeat (15) @(negedge clk);
        chk("R5 no valid while stopped", 32'(cmd_valid), 32'd0);
        rd_reg(2'd1, v); chk("R5 rptr unchanged", 32'(v), 32'h0);

        wr_reg(2'd3, 16'h0001);
        drain("R2");
        rd_reg(2'd1, v); chk("R3 rptr after three", 32'(v), 32'h3);

        // R8 upper pointer bits ignored
        wr_reg(2'd0, 16'hAB03);
        rd_reg(2'd0, v); chk("R8 wptr readback", 32'(v), 32'h0003);
        repeat (8) @(negedge clk);
        chk("R8 no fetch", 32'(cmd_valid), 32'd0);

        // R11 restart after idle, random back-pressure
        rdy_mode = 1;
        for (int i = 0; i < 6; i++) push_cmd({4'(i + 4), 20'h0, 8'(i + 4)});
        drain("R11");
        rd_reg(2'd1, v); chk("R11 rptr", 32'(v), 32'd9);

        // R9 wrap across 255
        for (int i = 0; i < 260; i++) push_cmd({4'(i % 15), 12'hA5, 16'(i)});
        drain("R9");
        rd_reg(2'd1, v); chk("R9 rptr after wrap", 32'(v), 32'd13);

        // R4 reset handshake
        wr_reg(2'd3, 16'h0000);
        wr_reg(2'd0, 16'h0000);
        sw_wp = 0;
        wr_reg(2'd1, 16'h8000);
        rd_reg(2'd1, v); chk("R4 flag reads set", 32'(v), 32'h8000);
        wr_reg(2'd3, 16'h0001);
        ring_put(8'd1, 32'h7000_0777);
        wr_reg(2'd0, 16'h0001);
        repeat (10) @(negedge clk);
        chk("R4 no fetch while held", 32'(cmd_valid), 32'd0);
        rd_reg(2'd1, v); chk("R4 still held", 32'(v), 32'h8000);
        exp_q.push_back(32'h7000_0777);
        sw_wp = 1;
        wr_reg(2'd1, 16'h0000);
        rd_reg(2'd1, v); chk("R4 released reads zero", 32'(v), 32'h0000);
        drain("R4");
        rd_reg(2'd1, v); chk("R4 fetch resumed", 32'(v), 32'h0001);

        // R12 reset drops an offered word
        rdy_mode = 0;
        repeat (2) @(negedge clk);
        ring_put(8'd2, 32'h9000_0999);
        wr_reg(2'd0, 16'h0002);
        repeat (5) @(negedge clk);
        chk("R12 word offered", 32'(cmd_valid), 32'd1);
        drop_ok = 1'b1;
        wr_reg(2'd1, 16'h8000);
        chk("R12 valid dropped", 32'(cmd_valid), 32'd0);
        repeat (2) @(negedge clk);
        drop_ok = 1'b0;
        rd_reg(2'd1, v); chk("R12 rptr reset", 32'(v), 32'h8000);
        wr_reg(2'd3, 16'h0000);
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, 16'h0000);
        sw_wp = 0;
        wr_reg(2'd3, 16'h0001);

        // R10 sixteen-slot ring
        rdy_mode = 2;
        wr_reg(2'd2, 16'h0001);
        rd_reg(2'd2, v); chk("R10 size readback", 32'(v), 32'h1);
        sw_mask = 15;
        for (int i = 0; i < 20; i++) push_cmd({4'(i % 16), 12'h3C, 16'(i)});
        drain("R10");
        rd_reg(2'd1, v); chk("R10 rptr wraps at 16", 32'(v), 32'd4);
        chk("R10 idle", 32'(cmd_valid), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule